// File: doc/BRIEF.md
# Per-Core Read Admission Controller

This block decides, one request at a time, whether a read-side request from a single processor core may go onto the master read and snoop channels. Each request carries a 3-bit category code. The block keeps an outstanding counter for each category and a running total for the core. It admits the request only when the category counter and the total both have room. Completion strobes, each with its own category, free the slots again. An optional coherency port has its own linefill counter. That counter is kept apart from the core's budget.

Decisions are registered. A request presented in one cycle is answered by exactly one of `grant` or `stall` in the next cycle. A completion that lands in the same cycle as a request is credited before the room check, so a full counter can admit a new request while it frees an old one. A completion aimed at an empty counter is refused and flagged on `cmp_err`. Arbitration between cores and the formatting of transactions belong to other blocks.

Top module: `rd_admit_ctrl`

## Requirements
- R1: After a synchronous reset, `grant`, `stall`, `cmp_err`, `port_grant` and `port_stall` are low and every counter is empty, so the first eight valid requests that fit their category caps are granted.
- R2: A request with `req_valid` high in cycle k gives exactly one of `grant` and `stall` high in cycle k+1. With no request, both are low in cycle k+1.
- R3: The category caps are: code 0 data linefill 8, code 1 non-cacheable/device read 4, code 2 page-walk read 1, code 3 instruction linefill 3, code 4 coherency operation 5, code 5 barrier 1, code 6 DVM message 8. A DVM message takes one slot whether it has one part or two. A request whose category counter is at its cap is stalled.
- R4: No more than 8 requests of a core are outstanding across all categories. A request that would exceed this total is stalled, even when its category counter has room.
- R5: Code 7 is never granted. A completion that carries code 7 sets `cmp_err` in the next cycle.
- R6: A valid completion in the same cycle as a request is credited before the check. It frees a slot in the total, and also in the category when the category matches.
- R7: A completion for a category whose counter is zero sets `cmp_err` in the next cycle and leaves every counter unchanged.
- R8: The coherency port admits up to 4 outstanding linefills. These do not count toward the core total, and a port completion in the same cycle is credited first. A port completion with nothing outstanding sets `cmp_err`.
- R9: A completion that frees a slot lets the next request in that category be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request present |
| req_cat | input | 3 | Category code of the request |
| cmp_valid | input | 1 | Core completion strobe |
| cmp_cat | input | 3 | Category code of the completion |
| port_req_valid | input | 1 | Coherency-port linefill request |
| port_cmp_valid | input | 1 | Coherency-port linefill completion |
| grant | output | 1 | Core request admitted (registered) |
| stall | output | 1 | Core request refused (registered) |
| port_grant | output | 1 | Port request admitted (registered) |
| port_stall | output | 1 | Port request refused (registered) |
| cmp_err | output | 1 | Completion with no matching outstanding request (registered) |

## Verification
The assertions assume that a core request is held for one cycle and then withdrawn or presented again. They also assume that a refused completion causes no further action upstream. The counter properties take it for granted that increments happen only through admission. The stimulus drives every input at the falling edge, one decision per cycle. It issues completions only from a bench model of what is outstanding, except where it deliberately targets an empty category or uses code 7 to provoke the error flag.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam int NCAT  = 7;
  localparam int CAT_W = 3;

  typedef enum logic [CAT_W-1:0] {
    CAT_DLINE = 3'd0,
    CAT_NCDEV = 3'd1,
    CAT_WALK  = 3'd2,
    CAT_ILINE = 3'd3,
    CAT_COH   = 3'd4,
    CAT_BAR   = 3'd5,
    CAT_DVM   = 3'd6,
    CAT_BAD   = 3'd7
  } cat_e;
endpackage

// File: rtl/rac_slot_counter.sv
module rac_slot_counter #(
  parameter int CAP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic room,
  output logic take,
  output logic err
);
  localparam int W = (CAP < 2) ? 1 : $clog2(CAP + 1);

  logic [W-1:0] cnt_q;
  logic         empty;

  assign empty = (cnt_q == '0);
  assign take  = dec && !empty;
  assign err   = dec && empty;
  assign room  = (cnt_q < W'(CAP)) || take;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + W'(inc) - W'(take);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(CAP)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dec && empty && !inc) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/rd_admit_ctrl.sv
module rd_admit_ctrl
  import rac_pkg::*;
#(
  parameter int CAP_DLINE = 8,
  parameter int CAP_NCDEV = 4,
  parameter int CAP_WALK  = 1,
  parameter int CAP_ILINE = 3,
  parameter int CAP_COH   = 5,
  parameter int CAP_BAR   = 1,
  parameter int CAP_DVM   = 8,
  parameter int CAP_TOTAL = 8,
  parameter int CAP_PORT  = 4,
  parameter bit HAS_PORT  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CAT_W-1:0] req_cat,
  input  logic             cmp_valid,
  input  logic [CAT_W-1:0] cmp_cat,
  input  logic             port_req_valid,
  input  logic             port_cmp_valid,
  output logic             grant,
  output logic             stall,
  output logic             port_grant,
  output logic             port_stall,
  output logic             cmp_err
);
  localparam int NSLOT = 1 << CAT_W;

  function automatic int cap_of(input int idx);
    case (idx)
      0:       return CAP_DLINE;
      1:       return CAP_NCDEV;
      2:       return CAP_WALK;
      3:       return CAP_ILINE;
      4:       return CAP_COH;
      5:       return CAP_BAR;
      default: return CAP_DVM;
    endcase
  endfunction

  logic [NSLOT-1:0] cat_room, cat_take, cat_err, cat_inc, cat_dec;
  logic             tot_room, tot_take, tot_err;
  logic             port_room, port_take, port_err;
  logic             req_ok, port_ok, cat_code_ok;

  assign cat_code_ok = (req_cat != CAT_BAD);
  assign req_ok      = req_valid && cat_code_ok && cat_room[req_cat] && tot_room;

  genvar gi;
  generate
    for (gi = 0; gi < NCAT; gi++) begin : g_cat
      assign cat_inc[gi] = req_ok && (req_cat == CAT_W'(gi));
      assign cat_dec[gi] = cmp_valid && (cmp_cat == CAT_W'(gi));
      rac_slot_counter #(.CAP(cap_of(gi))) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (cat_inc[gi]),
        .dec (cat_dec[gi]),
        .room(cat_room[gi]),
        .take(cat_take[gi]),
        .err (cat_err[gi])
      );
    end
  endgenerate

  assign cat_inc[NSLOT-1]  = 1'b0;
  assign cat_dec[NSLOT-1]  = 1'b0;
  assign cat_room[NSLOT-1] = 1'b0;
  assign cat_take[NSLOT-1] = 1'b0;
  assign cat_err[NSLOT-1]  = cmp_valid && (cmp_cat == CAT_BAD);

  rac_slot_counter #(.CAP(CAP_TOTAL)) u_total (
    .clk (clk),
    .rst (rst),
    .inc (req_ok),
    .dec (|cat_take),
    .room(tot_room),
    .take(tot_take),
    .err (tot_err)
  );

  generate
    if (HAS_PORT) begin : g_port
      rac_slot_counter #(.CAP(CAP_PORT)) u_port (
        .clk (clk),
        .rst (rst),
        .inc (port_ok),
        .dec (port_cmp_valid),
        .room(port_room),
        .take(port_take),
        .err (port_err)
      );
    end else begin : g_noport
      assign port_room = 1'b0;
      assign port_take = 1'b0;
      assign port_err  = port_cmp_valid;
    end
  endgenerate

  assign port_ok = port_req_valid && port_room;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant      <= 1'b0;
      stall      <= 1'b0;
      port_grant <= 1'b0;
      port_stall <= 1'b0;
      cmp_err    <= 1'b0;
    end else begin
      grant      <= req_ok;
      stall      <= req_valid && !req_ok;
      port_grant <= port_ok;
      port_stall <= port_req_valid && !port_ok;
      cmp_err    <= (|cat_err) || port_err;
    end
  end

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (grant != stall)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!grant && !stall)); // R2
  AST_BAD_CODE_STALL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cat == CAT_BAD) |=> stall); // R5
  AST_TOTAL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|cat_take) |-> (tot_take && !tot_err)); // R4
  AST_PORT_ERR: assert property (@(posedge clk) disable iff (rst)
    (port_cmp_valid && !port_take) |=> cmp_err); // R8
endmodule

// File: tb/tb_rd_admit_ctrl.sv
`timescale 1ns/1ps
module tb_rd_admit_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, cmp_valid = 1'b0;
  logic [2:0] req_cat = 3'd0, cmp_cat = 3'd0;
  logic       port_req_valid = 1'b0, port_cmp_valid = 1'b0;
  logic       grant, stall, port_grant, port_stall, cmp_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rd_admit_ctrl dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_cat(req_cat),
    .cmp_valid(cmp_valid), .cmp_cat(cmp_cat),
    .port_req_valid(port_req_valid), .port_cmp_valid(port_cmp_valid),
    .grant(grant), .stall(stall),
    .port_grant(port_grant), .port_stall(port_stall), .cmp_err(cmp_err)
  );

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  int m_cnt[7];
  int m_tot;
  int m_port;
  int caps[7] = '{8, 4, 1, 3, 5, 1, 8};

  task automatic model_clear();
    for (int i = 0; i < 7; i++) m_cnt[i] = 0;
    m_tot  = 0;
    m_port = 0;
  endtask

  task automatic step(input logic rv, input logic [2:0] rc,
                      input logic cv, input logic [2:0] cc,
                      input logic pv, input logic pc, input string tag);
    logic ctake, ptake, g, pg, er;
    item_t it;
    @(negedge clk);
    req_valid = rv; req_cat = rc; cmp_valid = cv; cmp_cat = cc;
    port_req_valid = pv; port_cmp_valid = pc;
    ctake = cv && (cc != 3'd7) && (m_cnt[cc] > 0);
    ptake = pc && (m_port > 0);
    g  = rv && (rc != 3'd7) &&
         ((m_cnt[rc] < caps[rc]) || (ctake && cc == rc)) &&
         ((m_tot < 8) || ctake);
    pg = pv && ((m_port < 4) || ptake);
    er = (cv && !ctake) || (pc && !ptake);
    if (ctake) begin m_cnt[cc]--; m_tot--; end
    if (g) begin m_cnt[rc]++; m_tot++; end
    if (ptake) m_port--;
    if (pg) m_port++;
    it.exp = {g, rv && !g, pg, pv && !pg, er};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, "R2");
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = sb_q.pop_front();
      act = {grant, stall, port_grant, port_stall, cmp_err};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: {grant,stall,pgrant,pstall,err} actual %b expected %b",
                 it.tag, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R1: outputs low while reset is held
    checks++;
    if ({grant, stall, port_grant, port_stall, cmp_err} !== 5'b0) begin
      errors++;
      $display("FAIL R1: actual %b expected 00000",
               {grant, stall, port_grant, port_stall, cmp_err});
    end
    rst = 1'b0;
    idle();
    // R3/R4: data linefills up to 8, ninth stalls on total and category
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, 0, 0, "R3");
    // R4: total full, other category with room still stalls
    step(1, 3'd3, 0, 0, 0, 0, "R4");
    // R6: completion of same category credited in the same cycle
    step(1, 3'd0, 1, 3'd0, 0, 0, "R6");
    // R6: completion of another category frees the total
    step(1, 3'd1, 1, 3'd0, 0, 0, "R6");
    // R7: completion on an empty category is flagged and has no effect
    step(0, 0, 1, 3'd2, 0, 0, "R7");
    step(1, 3'd4, 0, 0, 0, 0, "R7");
    // R5: code 7 request and completion
    step(1, 3'd7, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 3'd7, 0, 0, "R5");
    // drain everything
    for (int c = 0; c < 7; c++)
      while (m_cnt[c] > 0) step(0, 0, 1, 3'(c), 0, 0, "R9");
    idle();
    // R3: each small cap in turn, then R9 refill after freeing
    for (int c = 1; c < 7; c++) begin
      for (int i = 0; i <= caps[c] && i < 8; i++) step(1, 3'(c), 0, 0, 0, 0, "R3");
      step(0, 0, 1, 3'(c), 0, 0, "R9");
      step(1, 3'(c), 0, 0, 0, 0, "R9");
      while (m_cnt[c] > 0) step(0, 0, 1, 3'(c), 0, 0, "R9");
    end
    // R8: port cap 4 is separate from the core total
    for (int i = 0; i < 8; i++) step(1, 3'd6, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 1, 1, "R8");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, "R8");
    // mixed pattern: request, completion and port at once
    step(1, 3'd6, 1, 3'd6, 1, 0, "R6");
    step(1, 3'd0, 0, 0, 1, 1, "R4");
    idle();
    // R1: reset mid-run empties every counter
    @(negedge clk);
    rst = 1'b1;
    req_valid = 0; cmp_valid = 0; port_req_valid = 0; port_cmp_valid = 0;
    @(negedge clk);
    sb_q.delete();
    model_clear();
    rst = 1'b0;
    for (int i = 0; i < 8; i++) step(1, 3'd0, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 3'd1, 0, 0, "R1");
    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule